// File: doc/BRIEF.md
# Interlocked Flash Mode Control Register

This block is the byte-wide control register that puts an on-chip flash array into one of its operating modes: program, erase, program-verify or erase-verify. Software reaches it over a simple byte bus. Every writable bit is guarded by a chain of enable bits that must already be set. The top bit is not stored. It mirrors the level of an external write-enable pin, so when that pin is low the array is protected in hardware.

A small bank of erase-block-select registers shares the same bus. They accept data only while software enable is set. The block also decodes the register into one mode state and four activity strobes for the flash sequencer. It flags whether ordinary array reads are allowed. All stored bits return to zero on reset and on either standby indication.

Top module: `flash_mode_ctrl`

Mode states and their `mode_state` codes:
- PROTECTED = 0: pin low or flash disabled.
- USER = 1: software enable clear.
- SW_ENABLED = 2: software enable set, no mode bit set.
- PROG_SETUP = 3
- PROGRAM = 4
- ERASE_SETUP = 5
- ERASE = 6
- PVERIFY = 7
- EVERIFY = 8

When several bits are set, the state is chosen in this priority order: program, erase, program-verify, erase-verify, program setup, erase setup.

Transitions:
- Any state goes to PROTECTED when the pin falls.
- USER goes to SW_ENABLED on a write that sets software enable.
- SW_ENABLED goes to a setup or verify state on the next accepted write.
- A setup state goes to PROGRAM or ERASE on a further write.
- Standby or reset takes any state back to USER or PROTECTED.

## Requirements
- R1: After reset, address 0 reads `{pin,7'b0}` (0x80 with the pin high, 0x00 with it low), and every erase-block register reads 0x00.
- R2: A write to bit 6 (software enable) at address 0 takes effect only while the pin is high.
- R3: Bits 5 (erase setup), 4 (program setup), 3 (erase-verify) and 2 (program-verify) change only if the pin is high and bit 6 was already 1 before the write. One write of 0x60 from 0x80 therefore gives 0xC0.
- R4: Bit 1 (erase) changes only if the pin is high and bits 6 and 5 were already set before the write. Bit 0 (program) changes only if the pin is high and bits 6 and 4 were already set before the write.
- R5: While `hw_standby` or `sw_standby` is high at a clock edge, bits 6..0 and all erase-block registers clear to 0.
- R6: While the pin is low at a clock edge, bits 6..0 clear to 0, and they stay clear when the pin returns high.
- R7: With `flash_en` low, every read returns 0x00 and bus writes change no register.
- R8: `array_read_ok` = `flash_en` and (not (pin and bit 6) or bit 3 or bit 2).
- R9: Erase-block registers (addresses 1..`NUM_BLK`) accept a write only when `flash_en` is high and bit 6 was 1 before the write.
- R10: `program_active`, `erase_active`, `pverify_active` and `everify_active` equal bits 0, 1, 2 and 3, each ANDed with the pin, bit 6 and `flash_en`.
- R11: `mode_state` follows the codes and the priority given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_pin | input | 1 | Write-enable pin level, already synchronised |
| flash_en | input | 1 | Flash-enable strap |
| hw_standby | input | 1 | Hardware standby indication |
| sw_standby | input | 1 | Software standby indication |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational readback |
| blk_sel | output | 8*NUM_BLK | Erase-block selects, register 1 in the low byte |
| program_active | output | 1 | Program strobe |
| erase_active | output | 1 | Erase strobe |
| pverify_active | output | 1 | Program-verify strobe |
| everify_active | output | 1 | Erase-verify strobe |
| array_read_ok | output | 1 | Normal array reads allowed |
| mode_state | output | 4 | Decoded mode code |

## Verification
The bench writes values that set an enable bit and a dependent bit in the same byte. A design that checked permission against the incoming data, rather than the stored state, would accept both bits in one step. It also writes the program bit while only erase setup is held, which catches a mix-up between the two enable chains. It drops the pin while a mode is active, and a design that only masked the readback would let the old bits return once the pin rose again. Finally, it writes with the flash disabled and pulses each standby input, so that leaking writes or uncleared erase-block registers show up on readback.

// File: rtl/flash_mode_pkg.sv
package flash_mode_pkg;
    localparam int DATA_W = 8;
    localparam int B_SWE  = 6;
    localparam int B_ESU  = 5;
    localparam int B_PSU  = 4;
    localparam int B_EV   = 3;
    localparam int B_PV   = 2;
    localparam int B_E    = 1;
    localparam int B_P    = 0;

    typedef enum logic [3:0] {
        MODE_PROTECTED   = 4'd0,
        MODE_USER        = 4'd1,
        MODE_SW_ENABLED  = 4'd2,
        MODE_PROG_SETUP  = 4'd3,
        MODE_PROGRAM     = 4'd4,
        MODE_ERASE_SETUP = 4'd5,
        MODE_ERASE       = 4'd6,
        MODE_PVERIFY     = 4'd7,
        MODE_EVERIFY     = 4'd8
    } mode_e;
endpackage

// File: rtl/flash_ctl_bits.sv
module flash_ctl_bits
    import flash_mode_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pin_hi,
    input  logic                  flash_en,
    input  logic                  clear_req,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-2:0]     ctl_q
);
    logic [DATA_W-2:0] ctl_nxt;
    logic              gate_sw;

    assign gate_sw = pin_hi && ctl_q[B_SWE];

    always_comb begin
        ctl_nxt = ctl_q;
        if (wr_en && flash_en) begin
            if (pin_hi)
                ctl_nxt[B_SWE] = wdata[B_SWE];
            if (gate_sw) begin
                ctl_nxt[B_ESU] = wdata[B_ESU];
                ctl_nxt[B_PSU] = wdata[B_PSU];
                ctl_nxt[B_EV]  = wdata[B_EV];
                ctl_nxt[B_PV]  = wdata[B_PV];
            end
            if (gate_sw && ctl_q[B_ESU])
                ctl_nxt[B_E] = wdata[B_E];
            if (gate_sw && ctl_q[B_PSU])
                ctl_nxt[B_P] = wdata[B_P];
        end
        if (clear_req || !pin_hi)
            ctl_nxt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl_q <= '0;
        else
            ctl_q <= ctl_nxt;
    end

    // R2
    swe_needs_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q[B_SWE]) |-> $past(pin_hi));
    // R3
    setup_needs_swe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctl_q[B_ESU]) || $rose(ctl_q[B_PSU])) |-> $past(ctl_q[B_SWE]));
    // R4
    erase_needs_esu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q[B_E]) |-> ($past(ctl_q[B_ESU]) && $past(ctl_q[B_SWE])));
    // R4
    prog_needs_psu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q[B_P]) |-> ($past(ctl_q[B_PSU]) && $past(ctl_q[B_SWE])));
    // R6
    pin_low_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_hi |=> (ctl_q == '0));
    // R5
    standby_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> (ctl_q == '0));
    // R7
    disabled_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flash_en) |=> ((ctl_q == $past(ctl_q)) || (ctl_q == '0)));
endmodule

// File: rtl/flash_blk_reg.sv
module flash_blk_reg
    import flash_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_enabled,
    input  logic              flash_en,
    input  logic              clear_req,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] blk_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            blk_q <= '0;
        else if (clear_req)
            blk_q <= '0;
        else if (wr_en && flash_en && sw_enabled)
            blk_q <= wdata;
    end

    // R9
    blk_needs_swe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(blk_q) && !$past(clear_req)) |-> $past(sw_enabled && flash_en));
endmodule

// File: rtl/flash_mode_decode.sv
module flash_mode_decode
    import flash_mode_pkg::*;
(
    input  logic              pin_hi,
    input  logic              flash_en,
    input  logic [DATA_W-2:0] ctl_q,
    output mode_e             mode,
    output logic              program_active,
    output logic              erase_active,
    output logic              pverify_active,
    output logic              everify_active,
    output logic              array_read_ok
);
    logic armed;

    assign armed = flash_en && pin_hi && ctl_q[B_SWE];

    always_comb begin
        if (!flash_en || !pin_hi)      mode = MODE_PROTECTED;
        else if (!ctl_q[B_SWE])        mode = MODE_USER;
        else if (ctl_q[B_P])           mode = MODE_PROGRAM;
        else if (ctl_q[B_E])           mode = MODE_ERASE;
        else if (ctl_q[B_PV])          mode = MODE_PVERIFY;
        else if (ctl_q[B_EV])          mode = MODE_EVERIFY;
        else if (ctl_q[B_PSU])         mode = MODE_PROG_SETUP;
        else if (ctl_q[B_ESU])         mode = MODE_ERASE_SETUP;
        else                           mode = MODE_SW_ENABLED;
    end

    always_comb begin
        program_active = 1'b0;
        erase_active   = 1'b0;
        pverify_active = 1'b0;
        everify_active = 1'b0;
        array_read_ok  = flash_en;
        unique case (mode)
            MODE_PROTECTED, MODE_USER: ;
            MODE_SW_ENABLED, MODE_PROG_SETUP, MODE_ERASE_SETUP,
            MODE_PROGRAM, MODE_ERASE, MODE_PVERIFY, MODE_EVERIFY: begin
                program_active = armed && ctl_q[B_P];
                erase_active   = armed && ctl_q[B_E];
                pverify_active = armed && ctl_q[B_PV];
                everify_active = armed && ctl_q[B_EV];
                array_read_ok  = ctl_q[B_PV] || ctl_q[B_EV];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
    import flash_mode_pkg::*;
#(
    parameter int NUM_BLK = 2,
    parameter int ADDR_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_pin,
    input  logic                      flash_en,
    input  logic                      hw_standby,
    input  logic                      sw_standby,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic [7:0]                bus_wdata,
    output logic [7:0]                bus_rdata,
    output logic [8*NUM_BLK-1:0]      blk_sel,
    output logic                      program_active,
    output logic                      erase_active,
    output logic                      pverify_active,
    output logic                      everify_active,
    output logic                      array_read_ok,
    output logic [3:0]                mode_state
);
    localparam int CTL_ADDR = 0;

    logic [DATA_W-2:0] ctl_q;
    logic              clear_req;
    logic              ctl_wr;
    logic [DATA_W-1:0] blk_q [NUM_BLK];
    mode_e             mode;

    assign clear_req = hw_standby || sw_standby;
    assign ctl_wr    = bus_wr && (int'(bus_addr) == CTL_ADDR);

    flash_ctl_bits u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_hi    (wr_pin),
        .flash_en  (flash_en),
        .clear_req (clear_req),
        .wr_en     (ctl_wr),
        .wdata     (bus_wdata),
        .ctl_q     (ctl_q)
    );

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
        flash_blk_reg u_blk (
            .clk        (clk),
            .rst_n      (rst_n),
            .sw_enabled (ctl_q[B_SWE]),
            .flash_en   (flash_en),
            .clear_req  (clear_req),
            .wr_en      (bus_wr && (int'(bus_addr) == g + 1)),
            .wdata      (bus_wdata),
            .blk_q      (blk_q[g])
        );
        assign blk_sel[8*g +: 8] = blk_q[g];
    end

    flash_mode_decode u_dec (
        .pin_hi         (wr_pin),
        .flash_en       (flash_en),
        .ctl_q          (ctl_q),
        .mode           (mode),
        .program_active (program_active),
        .erase_active   (erase_active),
        .pverify_active (pverify_active),
        .everify_active (everify_active),
        .array_read_ok  (array_read_ok)
    );

    assign mode_state = mode;

    always_comb begin
        bus_rdata = '0;
        if (flash_en) begin
            if (int'(bus_addr) == CTL_ADDR)
                bus_rdata = {wr_pin, ctl_q};
            for (int i = 0; i < NUM_BLK; i++)
                if (int'(bus_addr) == i + 1)
                    bus_rdata = blk_q[i];
        end
    end

    // R7
    disabled_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_en |-> (bus_rdata == 8'h00));
    // R10
    strobes_need_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (program_active || erase_active || pverify_active || everify_active)
            |-> (wr_pin && flash_en));
    // R10
    strobes_onehot_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pverify_active || everify_active) |-> array_read_ok);
endmodule

// File: tb/flash_mode_ctrl_bench.sv
module flash_mode_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_pin = 1'b1;
    logic        flash_en = 1'b1;
    logic        hw_standby = 1'b0;
    logic        sw_standby = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] blk_sel;
    logic        program_active, erase_active, pverify_active, everify_active;
    logic        array_read_ok;
    logic [3:0]  mode_state;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;   // 0 readback, 1 strobes {P,E,PV,EV,readok}, 2 mode
        logic [7:0]  exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    flash_mode_ctrl u_flash_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_pin(wr_pin), .flash_en(flash_en),
        .hw_standby(hw_standby), .sw_standby(sw_standby),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .blk_sel(blk_sel),
        .program_active(program_active), .erase_active(erase_active),
        .pverify_active(pverify_active), .everify_active(everify_active),
        .array_read_ok(array_read_ok), .mode_state(mode_state)
    );

    // monitor: compare at the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            case (it.kind)
                0: act = bus_rdata;
                1: act = {3'b0, program_active, erase_active, pverify_active,
                          everify_active, array_read_ok};
                default: act = {4'b0, mode_state};
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic expect_item(input int kind, input logic [1:0] a,
                               input logic [7:0] e, input string req);
        item_t it;
        bus_addr = a;
        it.kind = kind; it.exp = e; it.req = req;
        sb.push_back(it);
        step();
    endtask

    initial begin
        #2;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        expect_item(0, 0, 8'h80, "R1");
        expect_item(0, 1, 8'h00, "R1");
        expect_item(1, 0, 8'h01, "R8");
        expect_item(2, 0, 8'd1, "R11");
        wr(1, 8'hFF);
        expect_item(0, 1, 8'h00, "R9");
        wr(0, 8'h60);
        expect_item(0, 0, 8'hC0, "R3");
        expect_item(2, 0, 8'd2, "R11");
        expect_item(1, 0, 8'h00, "R8");
        wr(0, 8'h62);
        expect_item(0, 0, 8'hE0, "R4");
        expect_item(2, 0, 8'd5, "R11");
        wr(0, 8'h62);
        expect_item(0, 0, 8'hE2, "R4");
        expect_item(1, 0, 8'h08, "R10");
        expect_item(2, 0, 8'd6, "R11");
        wr(0, 8'h41);
        expect_item(0, 0, 8'hC0, "R4");
        wr(0, 8'h50);
        wr(0, 8'h51);
        expect_item(0, 0, 8'hD1, "R4");
        expect_item(1, 0, 8'h10, "R10");
        expect_item(2, 0, 8'd4, "R11");
        wr(0, 8'h44);
        expect_item(1, 0, 8'h05, "R8");
        expect_item(2, 0, 8'd7, "R11");
        wr(0, 8'h48);
        expect_item(1, 0, 8'h03, "R10");
        expect_item(2, 0, 8'd8, "R11");
        wr(1, 8'hA5);
        wr(2, 8'h3C);
        expect_item(0, 1, 8'hA5, "R9");
        expect_item(0, 2, 8'h3C, "R9");
        flash_en = 1'b0;
        expect_item(0, 0, 8'h00, "R7");
        expect_item(0, 1, 8'h00, "R7");
        expect_item(1, 0, 8'h00, "R7");
        wr(0, 8'h00);
        wr(1, 8'h11);
        flash_en = 1'b1;
        expect_item(0, 0, 8'hC8, "R7");
        expect_item(0, 1, 8'hA5, "R7");
        sw_standby = 1'b1; step(); sw_standby = 1'b0;
        expect_item(0, 0, 8'h80, "R5");
        expect_item(0, 2, 8'h00, "R5");
        wr(0, 8'h40);
        wr(0, 8'h48);
        hw_standby = 1'b1; step(); hw_standby = 1'b0;
        expect_item(0, 0, 8'h80, "R5");
        wr(0, 8'h40);
        wr(0, 8'h50);
        wr(0, 8'h51);
        wr_pin = 1'b0;
        expect_item(1, 0, 8'h01, "R10");
        expect_item(2, 0, 8'd0, "R11");
        wr_pin = 1'b1;
        expect_item(0, 0, 8'h80, "R6");
        wr_pin = 1'b0;
        wr(0, 8'h40);
        wr_pin = 1'b1;
        expect_item(0, 0, 8'h80, "R2");
        wr_pin = 1'b0;
        rst_n = 1'b0; step(); rst_n = 1'b1;
        expect_item(0, 0, 8'h00, "R1");
        wr_pin = 1'b1;
        step();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
        end
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule